// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a binary counter of parameterized width that steps up or down. Each direction has its own count enable. A synchronous parallel load has priority over counting, and an asynchronous active-high clear has priority over everything else. For each direction the counter reports whether it sits at the value that ends a count in that direction (all ones for up, all zeros for down). It also gives a gated cascade enable for each direction, built from that terminal flag and the matching enable.

Identical stages form a wider counter. The up cascade output of one stage drives the up enable of the next stage, and the down cascade output drives the next down enable. Clock, load and clear go to every stage in parallel. The wide terminal conditions are the AND of the stage flags. The cascade and terminal outputs are combinational, so a chain still steps in one clock edge for every carry or borrow.

Top module: `updown_cascade_counter`

## Requirements
- R1: While `clr` is 1, with or without a clock edge and whatever the other inputs are, `q` is 0, `term_up` is 0, `term_dn` is 1, and `casc_up` and `casc_dn` are both 0.
- R2: On a rising edge with `clr` at 0 and `load` at 1, `q` takes `din`, whatever `en_up` and `en_dn` are.
- R3: On a rising edge with `clr` and `load` at 0, `en_up` at 1 and `en_dn` at 0, `q` increments, and all ones wraps to 0.
- R4: On a rising edge with `clr` and `load` at 0, `en_dn` at 1 and `en_up` at 0, `q` decrements, and 0 wraps to all ones.
- R5: With `clr` and `load` at 0 and both enables at 0, `q` holds across edges, and `casc_up` and `casc_dn` are 0.
- R6: With `clr` and `load` at 0 and both enables at 1, a rising edge increments `q`.
- R7: `term_up` is 1 exactly when every bit of `q` is 1, and `term_dn` is 1 exactly when every bit of `q` is 0, whatever the enables are.
- R8: With `clr` at 0, `casc_up` equals `term_up AND en_up` and `casc_dn` equals `term_dn AND en_dn`, in the same cycle as the inputs.
- R9: A chain of N stages, with each `casc_up`/`casc_dn` wired to the next `en_up`/`en_dn`, counts as one N·WIDTH-bit up/down counter. The AND of all `term_up` flags is 1 only at all ones, and the AND of all `term_dn` flags is 1 only at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Synchronous parallel load enable |
| en_up | input | 1 | Count-up enable |
| en_dn | input | 1 | Count-down enable |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Counter value |
| term_up | output | 1 | High when q is all ones |
| term_dn | output | 1 | High when q is all zeros |
| casc_up | output | 1 | Carry enable for the next stage |
| casc_dn | output | 1 | Borrow enable for the next stage |

## Verification
The bench walks the counter across both wrap points. A design that saturates or drops the wrap would stall at all ones or zero. Load is issued with both enables high, and a design that lets counting win would land one step off the loaded value. Clear is raised between edges with the down enable high, which exposes a cascade output left ungated by clear or a clear that waits for the clock. A three-stage chain then crosses nibble boundaries in both directions, where a cascade output that depends on anything but the terminal flag and its own enable would corrupt the upper stages.

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             en_up,
  input  logic             en_dn,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term_up,
  output logic             term_dn,
  output logic             casc_up,
  output logic             casc_dn
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)        q <= '0;
    else if (load)  q <= din;
    else if (en_up) q <= q + STEP;
    else if (en_dn) q <= q - STEP;
  end

  assign term_up = &q;
  assign term_dn = ~|q;
  assign casc_up = term_up & en_up & ~clr;
  assign casc_dn = term_dn & en_dn & ~clr;

  // R2
  load_takes_din_chk: assert property (@(posedge clk) disable iff (clr)
    load |=> q == $past(din));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && en_up && !en_dn) |=> q == $past(q) + STEP);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && en_dn && !en_up) |=> q == $past(q) - STEP);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && !en_up && !en_dn) |=> $stable(q));

  // R6
  both_up_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && en_up && en_dn) |=> q == $past(q) + STEP);

  // R8
  idle_casc_chk: assert property (@(posedge clk) disable iff (clr)
    (!en_up && !en_dn) |-> (!casc_up && !casc_dn));
endmodule

// File: tb/updown_cascade_counter_tb.sv
module updown_cascade_counter_tb;
  localparam int W = 4;
  localparam int NSTG = 3;
  localparam int CW = NSTG * W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic clr, load, en_up, en_dn;
  logic [W-1:0] din, q;
  logic term_up, term_dn, casc_up, casc_dn;

  updown_cascade_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .clr(clr), .load(load), .en_up(en_up), .en_dn(en_dn),
    .din(din), .q(q), .term_up(term_up), .term_dn(term_dn),
    .casc_up(casc_up), .casc_dn(casc_dn));

  logic c_load, c_up, c_dn;
  logic [CW-1:0] c_din, c_q;
  logic [NSTG:0] up_link, dn_link;
  logic [NSTG-1:0] tu_all, td_all;

  assign up_link[0] = c_up;
  assign dn_link[0] = c_dn;
  for (genvar g = 0; g < NSTG; g++) begin : g_chain
    updown_cascade_counter #(.WIDTH(W)) u_stage (
      .clk(clk), .clr(clr), .load(c_load), .en_up(up_link[g]), .en_dn(dn_link[g]),
      .din(c_din[g*W +: W]), .q(c_q[g*W +: W]), .term_up(tu_all[g]), .term_dn(td_all[g]),
      .casc_up(up_link[g+1]), .casc_dn(dn_link[g+1]));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {load, en_up, en_dn, din[3:0], q[3:0], term_up, term_dn, casc_up, casc_dn}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {3'b111, 4'hE, 4'hE, 4'b0000},  // R2 load beats both enables
    {3'b010, 4'h0, 4'hF, 4'b1010},  // R3 R7 R8 up to all ones
    {3'b010, 4'h0, 4'h0, 4'b0100},  // R3 wrap up
    {3'b001, 4'h0, 4'hF, 4'b1000},  // R4 wrap down
    {3'b001, 4'h0, 4'hE, 4'b0000},  // R4
    {3'b000, 4'h0, 4'hE, 4'b0000},  // R5 hold
    {3'b011, 4'h0, 4'hF, 4'b1010},  // R6 both enables count up
    {3'b101, 4'h0, 4'h0, 4'b0101},  // R2 R8 load zero, down cascade
    {3'b000, 4'h0, 4'h0, 4'b0100},  // R5 R7 idle at zero
    {3'b100, 4'h5, 4'h5, 4'b0000},  // R2
    {3'b010, 4'h0, 4'h6, 4'b0000},  // R3
    {3'b001, 4'h0, 4'h5, 4'b0000}   // R4
  };

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] model;
    clr = 1'b1; load = 0; en_up = 0; en_dn = 1; din = '0;
    c_load = 0; c_up = 0; c_dn = 0; c_din = '0;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 q", q, 0);
    chk("R1 flags", {term_up, term_dn, casc_up, casc_dn}, 4'b0100);
    @(negedge clk);
    clr = 0; en_dn = 0;

    for (int i = 0; i < NV; i++) begin
      {load, en_up, en_dn, din} = VEC[i][14:8];
      @(posedge clk); #1;
      chk($sformatf("R2-R8 vec%0d q", i), q, VEC[i][7:4]);
      chk($sformatf("R7 R8 vec%0d flags", i), {term_up, term_dn, casc_up, casc_dn}, VEC[i][3:0]);
      @(negedge clk);
    end

    // R5 hold over several edges with nothing enabled
    load = 0; en_up = 0; en_dn = 0;
    repeat (3) @(posedge clk);
    #1 chk("R5 multi-edge hold", q, 4'h5);

    // R1 asynchronous clear between edges with down enable high
    @(negedge clk);
    en_dn = 1;
    #2 clr = 1;
    #1 chk("R1 async q", q, 0);
    chk("R1 async flags", {term_up, term_dn, casc_up, casc_dn}, 4'b0100);
    load = 1; din = 4'hA;
    @(posedge clk); #1;
    chk("R1 clear beats load", q, 0);
    @(negedge clk);
    clr = 0; load = 0; en_dn = 1;
    #1 chk("R8 down cascade after clear", casc_dn, 1);

    // R9 chain: up across boundaries and full wrap
    c_load = 1; c_din = 12'hFFD;
    @(posedge clk); @(negedge clk);
    c_load = 0; c_up = 1;
    model = 12'hFFD;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      model = model + 1'b1;
      chk("R9 chain up", c_q, model);
      chk("R9 chain terms", {&tu_all, &td_all}, {model == '1, model == '0});
      @(negedge clk);
    end
    c_load = 1; c_up = 0; c_din = 12'h0FE;
    @(posedge clk); @(negedge clk);
    c_load = 0; c_up = 1; model = 12'h0FE;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      model = model + 1'b1;
      chk("R9 chain carry", c_q, model);
      @(negedge clk);
    end
    c_up = 0; c_dn = 1;
    c_load = 1; c_din = 12'h002;
    @(posedge clk); @(negedge clk);
    c_load = 0; model = 12'h002;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      model = model - 1'b1;
      chk("R9 chain down", c_q, model);
      chk("R9 chain terms", {&tu_all, &td_all}, {model == '1, model == '0});
      @(negedge clk);
    end
    c_dn = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule